// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block times single bits on an I2C bus as a master. It reads its whole timing setup from one 32-bit word: a 4-bit prescaler, an SDA hold delay, an SCL setup delay, and separate SCL low and high counts. For each bit request it pulls SCL low and waits out the hold delay. It then drives or releases SDA and waits out the setup delay, with the low count running at the same time. Once both have expired it releases SCL. The high count starts only when the block observes SCL high, so a target that stretches the clock lengthens the high phase. At the end of the high phase the block samples SDA and pulls SCL low again.

Both bus lines pass through a two-flop synchronizer and a programmable digital filter before the block acts on them. Byte sequencing, START/STOP generation and target mode are handled elsewhere. Between bits the block holds SCL low and keeps SDA as it last set it.

Top module: `i2c_timing_gen`

## Requirements
- R1: While `en` is low, `scl_drive_low` and `sda_drive_low` are both 0 one cycle later, `bit_ready` is 0, and `bit_req` has no effect. A reset puts the block in that same released, idle state.
- R2: The timing word is decoded as follows: prescaler P in bits 31:28, setup S in bits 23:20, hold H in bits 19:16, high count HI in bits 15:8, low count LO in bits 7:0. Bits 27:24 have no effect on any timing.
- R3: Counted from the clock edge that accepts a request, the SDA drive changes exactly H*(P+1)+1 clocks later.
- R4: Counted from the accepting edge, SCL is driven low for exactly max((LO+1)*(P+1), H*(P+1)+1+(S+1)*(P+1)) clocks. When the two windows end on the same cycle, no extra cycle is added.
- R5: If no target stretches SCL, the block releases SCL for exactly (HI+1)*(P+1)+3+max(F,1) clocks, where F is the filter length.
- R6: If a target holds SCL low for K further clocks after the release, the released time grows by exactly K clocks.
- R7: A high pulse on SCL shorter than F clocks (F at least 1) is ignored and does not start the high count.
- R8: `rx_valid` pulses for one cycle in the cycle in which SCL is driven low again. `rx_bit` then holds the filtered SDA level.
- R9: On a write bit, SDA is driven low for a 0 and released for a 1. On a read bit, SDA is released.
- R10: `bit_ready` is high only when the block is enabled and idle. Between bits SCL stays driven low.
- R11: Dropping `en` in the middle of a bit releases both lines on the next cycle. After `en` returns, the next bit runs with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| timing_cfg | input | 32 | Packed timing word |
| filt_len | input | FLT_W (5) | Digital filter length in clocks, 0 to 16 |
| scl_in | input | 1 | Observed SCL line level |
| sda_in | input | 1 | Observed SDA line level |
| bit_req | input | 1 | Start one bit, accepted while `bit_ready` is high |
| bit_is_read | input | 1 | 1 for a read bit (SDA released) |
| bit_val | input | 1 | Value of a write bit |
| bit_ready | output | 1 | Enabled and idle |
| scl_drive_low | output | 1 | Open-drain SCL pull-down enable |
| sda_drive_low | output | 1 | Open-drain SDA pull-down enable |
| rx_bit | output | 1 | SDA level sampled at the end of the high phase |
| rx_valid | output | 1 | One-cycle strobe for `rx_bit` |

## Verification
Two pairs of functions can fall on the same cycle. In the first pair, the low-count window and the hold-plus-setup window end together. The first directed bit uses a timing word in which both equal five clocks, and the bench checks that SCL is held low for exactly five clocks, neither six nor four. In the second pair, the high count expires in the same cycle in which SCL is pulled low again and SDA is sampled. The bench judges this by seeing the one-cycle strobe in the first sample after the release ends, together with the bit the target drove. The bench also checks it during a stretched, glitched high phase, where the filter has to reject the short pulse first.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

    localparam int CNT_W = 13;

    typedef struct packed {
        logic [3:0] presc;
        logic [3:0] spare;
        logic [3:0] setup;
        logic [3:0] hold;
        logic [7:0] high;
        logic [7:0] low;
    } tword_t;

    typedef struct packed {
        logic [CNT_W-1:0] t_hold;
        logic [CNT_W-1:0] t_rel;
        logic [CNT_W-1:0] t_high;
    } targets_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOW   = 2'd1,
        PH_HWAIT = 2'd2,
        PH_HIGH  = 2'd3
    } phase_t;

    function automatic logic [CNT_W-1:0] scaled(input logic [8:0] n, input logic [3:0] p);
        logic [13:0] prod;
        prod = 14'(n) * 14'({1'b0, p} + 5'd1);
        return prod[CNT_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] low_clocks(input tword_t w);
        return scaled({1'b0, w.low} + 9'd1, w.presc);
    endfunction

    function automatic targets_t calc_targets(input tword_t w);
        targets_t t;
        logic [CNT_W-1:0] t_setup;
        logic [CNT_W-1:0] t_low;
        logic [CNT_W-1:0] t_win;
        t.t_hold = scaled({5'd0, w.hold}, w.presc) + CNT_W'(1);
        t_setup  = scaled({5'd0, w.setup} + 9'd1, w.presc);
        t_low    = low_clocks(w);
        t_win    = t.t_hold + t_setup;
        t.t_rel  = (t_win > t_low) ? t_win : t_low;
        t.t_high = scaled({1'b0, w.high} + 9'd1, w.presc);
        return t;
    endfunction

endpackage

// File: rtl/i2c_tg_filter.sv
module i2c_tg_filter #(
    parameter int FLT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic [FLT_W-1:0] len,
    output logic             filt
);
    logic [1:0]       sync_q;
    logic [FLT_W-1:0] run_q;
    logic [FLT_W:0]   run_next;

    assign run_next = {1'b0, run_q} + (FLT_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            filt   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == filt) begin
                run_q <= '0;
            end else if (run_next >= {1'b0, len}) begin
                filt  <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_next[FLT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/i2c_tg_fsm.sv
module i2c_tg_fsm
    import i2c_tg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  targets_t tgt,
    input  logic     req,
    input  logic     is_read,
    input  logic     val,
    input  logic     scl_f,
    input  logic     sda_f,
    output logic     scl_oe,
    output logic     sda_oe,
    output logic     ready,
    output logic     rx_bit,
    output logic     rx_valid
);
    phase_t           ph_q;
    logic [CNT_W-1:0] ecnt_q;
    logic [CNT_W-1:0] ecnt_inc;
    logic             rd_q;
    logic             val_q;
    logic             saw_low_q;

    assign ecnt_inc = ecnt_q + CNT_W'(1);
    assign ready    = en && (ph_q == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_q      <= PH_IDLE;
            ecnt_q    <= '0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            rx_bit    <= 1'b0;
            rx_valid  <= 1'b0;
            rd_q      <= 1'b0;
            val_q     <= 1'b0;
            saw_low_q <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (req) begin
                        ph_q      <= PH_LOW;
                        ecnt_q    <= '0;
                        scl_oe    <= 1'b1;
                        rd_q      <= is_read;
                        val_q     <= val;
                        saw_low_q <= 1'b0;
                    end
                end
                PH_LOW: begin
                    ecnt_q <= ecnt_inc;
                    if (!scl_f) saw_low_q <= 1'b1;
                    if (ecnt_inc == tgt.t_hold) sda_oe <= ~rd_q & ~val_q;
                    if (ecnt_inc >= tgt.t_rel) begin
                        ph_q   <= PH_HWAIT;
                        scl_oe <= 1'b0;
                    end
                end
                PH_HWAIT: begin
                    if (!scl_f) begin
                        saw_low_q <= 1'b1;
                    end else if (saw_low_q) begin
                        ph_q   <= PH_HIGH;
                        ecnt_q <= '0;
                    end
                end
                PH_HIGH: begin
                    ecnt_q <= ecnt_inc;
                    if (ecnt_inc >= tgt.t_high) begin
                        ph_q     <= PH_IDLE;
                        scl_oe   <= 1'b1;
                        rx_bit   <= sda_f;
                        rx_valid <= 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_timing_gen.sv
module i2c_timing_gen
    import i2c_tg_pkg::*;
#(
    parameter int FLT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [31:0]      timing_cfg,
    input  logic [FLT_W-1:0] filt_len,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             bit_req,
    input  logic             bit_is_read,
    input  logic             bit_val,
    output logic             bit_ready,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             rx_bit,
    output logic             rx_valid
);
    localparam int NLINES = 2;

    tword_t              word;
    targets_t            tgt;
    logic [NLINES-1:0]   line_raw;
    logic [NLINES-1:0]   line_filt;

    assign word     = tword_t'(timing_cfg);
    assign tgt      = calc_targets(word);
    assign line_raw = {sda_in, scl_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        i2c_tg_filter #(.FLT_W(FLT_W)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (line_raw[i]),
            .len  (filt_len),
            .filt (line_filt[i])
        );
    end

    i2c_tg_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tgt      (tgt),
        .req      (bit_req),
        .is_read  (bit_is_read),
        .val      (bit_val),
        .scl_f    (line_filt[0]),
        .sda_f    (line_filt[1]),
        .scl_oe   (scl_drive_low),
        .sda_oe   (sda_drive_low),
        .ready    (bit_ready),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/i2c_timing_gen_chk.sv
module i2c_timing_gen_chk
    import i2c_tg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [31:0] timing_cfg,
    input logic        scl_drive_low,
    input logic        sda_drive_low,
    input logic        rx_valid
);
    logic [15:0]      ones_q;
    logic [15:0]      zeros_q;
    logic [CNT_W-1:0] need_low;
    logic [CNT_W-1:0] need_high;

    assign need_low  = low_clocks(tword_t'(timing_cfg));
    assign need_high = calc_targets(tword_t'(timing_cfg)).t_high + CNT_W'(4);

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q  <= '0;
            zeros_q <= '0;
        end else begin
            ones_q  <= scl_drive_low  ? ((ones_q  == 16'hFFFF) ? ones_q  : ones_q  + 16'd1) : 16'd0;
            zeros_q <= !scl_drive_low ? ((zeros_q == 16'hFFFF) ? zeros_q : zeros_q + 16'd1) : 16'd0;
        end
    end

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_drive_low && !sda_drive_low)); // R1

    AST_SDA_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (sda_drive_low != $past(sda_drive_low))) |-> (scl_drive_low && $past(scl_drive_low))); // R3

    AST_LOW_AT_LEAST: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !scl_drive_low && $past(scl_drive_low)) |-> (ones_q >= 16'(need_low))); // R4

    AST_HIGH_AT_LEAST: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (zeros_q >= 16'(need_high))); // R5

    AST_SAMPLE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (scl_drive_low && !$past(scl_drive_low))); // R8

    AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R8
endmodule

bind i2c_timing_gen i2c_timing_gen_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .timing_cfg    (timing_cfg),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .rx_valid      (rx_valid)
);

// File: tb/i2c_timing_gen_tb_top.sv
module i2c_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] timing_cfg = 32'h0;
    logic [4:0]  filt_len = 5'd0;
    logic        bit_req = 1'b0;
    logic        bit_is_read = 1'b0;
    logic        bit_val = 1'b0;
    logic        scl_hold = 1'b0;
    logic        tgt_sda_low = 1'b0;
    logic        bit_ready, scl_drive_low, sda_drive_low, rx_bit, rx_valid;
    logic        scl_line, sda_line;
    int          checks = 0;
    int          fails = 0;

    always #4 clk = ~clk;

    assign scl_line = ~scl_drive_low & ~scl_hold;
    assign sda_line = ~sda_drive_low & ~tgt_sda_low;

    i2c_timing_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .timing_cfg    (timing_cfg),
        .filt_len      (filt_len),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .bit_req       (bit_req),
        .bit_is_read   (bit_is_read),
        .bit_val       (bit_val),
        .bit_ready     (bit_ready),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .rx_bit        (rx_bit),
        .rx_valid      (rx_valid)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic run_bit(input bit is_read, input bit val, input int exp_low, input int exp_hold,
                           input int exp_high, input int stretch, input int g_at, input int g_len,
                           input bit exp_rx, input string tag);
        int  low_n = 0;
        int  hold_n = 0;
        int  high_n = 0;
        int  guard = 0;
        logic prev_sda;
        @(negedge clk);
        check(bit_ready == 1'b1, "R10", {tag, " ready before bit"}, int'(bit_ready), 1);
        prev_sda    = sda_drive_low;
        bit_req     = 1'b1;
        bit_is_read = is_read;
        bit_val     = val;
        if (stretch > 0) scl_hold = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
        while (scl_drive_low && guard < 20000) begin
            if (sda_drive_low == prev_sda) hold_n++;
            low_n++;
            guard++;
            @(negedge clk);
        end
        while (!scl_drive_low && guard < 40000) begin
            if (g_len > 0 && high_n == g_at) scl_hold = 1'b0;
            if (g_len > 0 && high_n == g_at + g_len) scl_hold = 1'b1;
            if (high_n == stretch) scl_hold = 1'b0;
            high_n++;
            guard++;
            @(negedge clk);
        end
        check(low_n == exp_low, "R4", {tag, " SCL low clocks"}, low_n, exp_low);
        if (exp_hold >= 0)
            check(hold_n == exp_hold, "R3", {tag, " SDA hold clocks"}, hold_n, exp_hold);
        if (stretch > 0)
            check(high_n == exp_high, "R6", {tag, " stretched high clocks"}, high_n, exp_high);
        else
            check(high_n == exp_high, "R5", {tag, " SCL high clocks"}, high_n, exp_high);
        check(rx_valid == 1'b1, "R8", {tag, " sample strobe"}, int'(rx_valid), 1);
        check(rx_bit == exp_rx, "R8", {tag, " sampled bit"}, int'(rx_bit), int'(exp_rx));
        check(sda_drive_low == (!is_read && !val), "R9", {tag, " SDA drive"},
              int'(sda_drive_low), int'(!is_read && !val));
        @(negedge clk);
        check(rx_valid == 1'b0, "R8", {tag, " strobe one cycle"}, int'(rx_valid), 0);
        check(scl_drive_low == 1'b1 && bit_ready == 1'b1, "R10", {tag, " SCL held low when idle"},
              int'(scl_drive_low), 1);
    endtask

    task automatic t_reset_disabled();
        @(negedge clk);
        check(!scl_drive_low && !sda_drive_low && !rx_valid, "R1", "reset lines released",
              int'({scl_drive_low, sda_drive_low, rx_valid}), 0);
        check(bit_ready == 1'b0, "R1", "not ready when disabled", int'(bit_ready), 0);
        bit_req = 1'b1;
        repeat (3) @(negedge clk);
        bit_req = 1'b0;
        check(!scl_drive_low && !sda_drive_low, "R1", "request ignored when disabled",
              int'({scl_drive_low, sda_drive_low}), 0);
    endtask

    task automatic t_drop_enable();
        @(negedge clk);
        bit_req = 1'b1; bit_is_read = 1'b0; bit_val = 1'b0;
        @(negedge clk);
        bit_req = 1'b0;
        repeat (3) @(negedge clk);
        check(scl_drive_low && sda_drive_low, "R11", "mid-bit lines driven", int'({scl_drive_low, sda_drive_low}), 3);
        en = 1'b0;
        @(negedge clk);
        check(!scl_drive_low && !sda_drive_low, "R11", "drop releases lines",
              int'({scl_drive_low, sda_drive_low}), 0);
        check(bit_ready == 1'b0, "R1", "not ready after drop", int'(bit_ready), 0);
        repeat (4) @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_disabled();
        en = 1'b1;
        // R4 coincident windows: low 5, hold+setup 5
        timing_cfg = 32'h0012_0304; filt_len = 5'd0;
        run_bit(1'b0, 1'b0, 5, 3, 8, 0, 0, 0, 1'b0, "cfg-a");
        timing_cfg = 32'h1021_0201; filt_len = 5'd2;
        run_bit(1'b0, 1'b1, 9, 3, 11, 0, 0, 0, 1'b1, "cfg-b");
        timing_cfg = 32'h2000_0105; filt_len = 5'd3;
        run_bit(1'b0, 1'b0, 18, 1, 12, 0, 0, 0, 1'b0, "cfg-c");
        // R6 stretch of 5 with a 2-clock glitch rejected (R7)
        run_bit(1'b1, 1'b0, 18, 1, 17, 5, 1, 2, 1'b1, "R7 stretch-glitch");
        timing_cfg = 32'h0012_0304; filt_len = 5'd0; tgt_sda_low = 1'b1;
        run_bit(1'b1, 1'b1, 5, -1, 8, 0, 0, 0, 1'b0, "read-zero");
        tgt_sda_low = 1'b0;
        // R2 spare bits 27:24 set
        timing_cfg = 32'h0F12_0304;
        run_bit(1'b0, 1'b0, 5, 3, 8, 0, 0, 0, 1'b0, "R2 spare");
        timing_cfg = 32'hF0FF_FF00; filt_len = 5'd16;
        run_bit(1'b0, 1'b1, 497, 241, 4115, 0, 0, 0, 1'b1, "max");
        timing_cfg = 32'h0012_0304; filt_len = 5'd0;
        t_drop_enable();
        run_bit(1'b0, 1'b1, 5, -1, 8, 0, 0, 0, 1'b1, "R11 recover");
        finish_run();
    end
endmodule